// File: doc/BRIEF.md
# Word/Byte Arithmetic Logic Unit with Condition Flags

This block is a registered arithmetic and logic unit for a 16-bit datapath that can also work on the low byte alone. Each cycle in which `en_i` is high it takes two operands, a 4-bit operation code, a byte/word select and the incoming carry flag. One clock later it presents the result and six condition flags: carry, nibble (auxiliary) carry, parity, zero, sign and signed overflow.

The operations are add, add with carry, subtract, subtract with borrow, increment, decrement, negate, compare, AND, OR, XOR, complement, and a one-bit shift left or right. Each operation writes only the outputs it is defined to affect. Compare writes the flags and leaves the result register alone. Complement writes the result and leaves every flag alone. Increment and decrement pass the incoming carry through to the carry flag.

A sequencer places the unit between its register file and its flag register. It feeds the stored carry back in on `carry_i` and reads the result and flags one cycle after issuing the operation.

Top module: `alu16`

## Requirements
- R1: While `rst_ni` is low, `result_o` and all six flag outputs are 0.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, INC=4, DEC=5, NEG=6, CMP=7, AND=8, OR=9, XOR=A, NOT=B, SHL=C, SHR=D. ADD/ADC give a+b(+carry_i for ADC), and SUB/SBB give a−b(−carry_i for SBB), modulo the active width. `cf_o` is set on an unsigned carry out of the top bit for additions and on a borrow for subtractions.
- R3: `af_o` is set on a carry from bit 3 into bit 4 for the add family, or a borrow from bit 4 into bit 3 for the subtract family. The add family is ADD, ADC and INC; the subtract family is SUB, SBB, DEC, NEG and CMP. Logic and shift operations clear it.
- R4: For every flag-writing operation, `pf_o` is 1 when bits 7:0 of the result hold an even number of ones, in both widths. `zf_o` is 1 when the active-width result is zero. `sf_o` equals the result's top active bit.
- R5: For all arithmetic operations, `of_o` is set when the result of the operation, read as two's complement in the active width, overflowed.
- R6: INC (a+1) and DEC (a−1) set `cf_o` equal to `carry_i` and update every other flag as R3–R5 require.
- R7: NEG gives 0−a, the inverted operand plus one; for example, byte 35h gives CBh. `cf_o` is set exactly when a is nonzero.
- R8: CMP sets all flags exactly as SUB would for the same operands and leaves `result_o` unchanged.
- R9: AND, OR and XOR clear `cf_o`, `of_o` and `af_o`. NOT gives the bitwise inverse of a and leaves all six flags unchanged.
- R10: SHL shifts a left by one, inserting 0. It sets `cf_o` to the old top bit and `of_o` to `cf_o` XOR the new top bit. SHR shifts a right by one, inserting 0. It sets `cf_o` to old bit 0 and `of_o` to the old top bit. Both clear `af_o`.
- R11: When `byte_i`=1, only bits 7:0 of the operands are used. Bits 15:8 of a written result are 0, and carry, sign and overflow come from bit 7.
- R12: Results and flags appear one clock after an enabled cycle. With `en_i` low, or with op codes E and F, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Perform the operation this cycle |
| op_i | input | 4 | Operation code (R2) |
| byte_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| a_i | input | 16 | First operand (destination) |
| b_i | input | 16 | Second operand (source) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 16 | Registered result |
| cf_o | output | 1 | Carry / borrow flag |
| af_o | output | 1 | Nibble carry / borrow flag |
| pf_o | output | 1 | Even parity of result bits 7:0 |
| zf_o | output | 1 | Result is zero |
| sf_o | output | 1 | Sign of result |
| of_o | output | 1 | Signed overflow |

## Verification
The only state is the result register and the flag register, so a wrong internal value shows up at the ports in the cycle after the operation that wrote it. A flag that is wrongly written or wrongly held stays visible until the next operation that is allowed to write it. The bench checks this by following CMP, NOT, idle cycles and codes E/F with compares against a model that tracks which outputs each operation may touch. A mistake in the carry chain or in the byte masking appears only at boundary operands, so directed corner values come before a pseudo-random sweep over all codes and both widths.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'h0, OP_ADC = 4'h1, OP_SUB = 4'h2, OP_SBB = 4'h3,
    OP_INC = 4'h4, OP_DEC = 4'h5, OP_NEG = 4'h6, OP_CMP = 4'h7,
    OP_AND = 4'h8, OP_OR  = 4'h9, OP_XOR = 4'hA, OP_NOT = 4'hB,
    OP_SHL = 4'hC, OP_SHR = 4'hD, OP_RS0 = 4'hE, OP_RS1 = 4'hF
  } op_e;

  typedef struct packed {
    logic cf;
    logic af;
    logic pf;
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
  import alu16_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,   // carry for add, borrow for sub
  input  logic              sub_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              of_o
);
  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] xm, ym, yinv;
  logic [DATA_W:0]   s;
  logic              c_in, co, xs, ys, ss;

  always_comb begin
    yinv = sub_i ? ~y_i : y_i;
    xm   = byte_i ? (x_i & LO_MASK) : x_i;
    ym   = byte_i ? (yinv & LO_MASK) : yinv;
    c_in = sub_i ^ cin_i;   // a - b - bw = a + ~b + !bw
    s    = {1'b0, xm} + {1'b0, ym} + {{DATA_W{1'b0}}, c_in};
    co   = byte_i ? s[BYTE_W] : s[DATA_W];
    sum_o = byte_i ? (s[DATA_W-1:0] & LO_MASK) : s[DATA_W-1:0];
    xs   = byte_i ? xm[BYTE_W-1] : xm[DATA_W-1];
    ys   = byte_i ? ym[BYTE_W-1] : ym[DATA_W-1];
    ss   = byte_i ? s[BYTE_W-1]  : s[DATA_W-1];
    cf_o = co ^ sub_i;
    af_o = (xm[NIB_W] ^ ym[NIB_W] ^ s[NIB_W]) ^ sub_i;
    of_o = (xs == ys) && (ss != xs);
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  op_e               op_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cf_o,
  output logic              of_o
);
  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] am, bm, raw;
  logic              a_top, r_top;

  always_comb begin
    am   = byte_i ? (a_i & LO_MASK) : a_i;
    bm   = byte_i ? (b_i & LO_MASK) : b_i;
    cf_o = 1'b0;
    of_o = 1'b0;
    a_top = byte_i ? am[BYTE_W-1] : am[DATA_W-1];
    unique case (op_i)
      OP_AND:  raw = am & bm;
      OP_OR:   raw = am | bm;
      OP_XOR:  raw = am ^ bm;
      OP_NOT:  raw = ~am;
      OP_SHL:  raw = {am[DATA_W-2:0], 1'b0};
      OP_SHR:  raw = {1'b0, am[DATA_W-1:1]};
      default: raw = '0;
    endcase
    res_o = byte_i ? (raw & LO_MASK) : raw;
    r_top = byte_i ? res_o[BYTE_W-1] : res_o[DATA_W-1];
    if (op_i == OP_SHL) begin
      cf_o = a_top;
      of_o = a_top ^ r_top;
    end else if (op_i == OP_SHR) begin
      cf_o = am[0];
      of_o = a_top;
    end
  end
endmodule

// File: rtl/alu16_stat.sv
module alu16_stat
  import alu16_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              byte_i,
  output logic              pf_o,
  output logic              zf_o,
  output logic              sf_o
);
  always_comb begin
    pf_o = ~^res_i[BYTE_W-1:0];   // low byte only, any width
    zf_o = (res_i == '0);
    sf_o = byte_i ? res_i[BYTE_W-1] : res_i[DATA_W-1];
  end
endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              pf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  op_e               op;
  logic [DATA_W-1:0] as_x, as_y, as_sum, lg_res, val;
  logic              as_cin, as_sub, as_cf, as_af, as_of;
  logic              lg_cf, lg_of;
  logic              st_pf, st_zf, st_sf;
  logic              is_arith, wr_res, wr_flg;
  flags_t            nxt_f, flags_q;
  logic [DATA_W-1:0] result_q;

  assign op = op_e'(op_i);

  always_comb begin
    as_x   = a_i;
    as_y   = b_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_ADC: as_cin = carry_i;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin as_sub = 1'b1; as_cin = carry_i; end
      OP_INC: as_y = ONE;
      OP_DEC: begin as_y = ONE; as_sub = 1'b1; end
      OP_NEG: begin as_x = '0; as_y = a_i; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu16_addsub #(.DATA_W(DATA_W)) u_addsub (
    .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub), .byte_i(byte_i),
    .sum_o(as_sum), .cf_o(as_cf), .af_o(as_af), .of_o(as_of)
  );

  alu16_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op), .byte_i(byte_i),
    .res_o(lg_res), .cf_o(lg_cf), .of_o(lg_of)
  );

  assign is_arith = (op_i[3] == 1'b0);
  assign val      = is_arith ? as_sum : lg_res;

  alu16_stat #(.DATA_W(DATA_W)) u_stat (
    .res_i(val), .byte_i(byte_i), .pf_o(st_pf), .zf_o(st_zf), .sf_o(st_sf)
  );

  always_comb begin
    wr_res = (op != OP_CMP) && (op != OP_RS0) && (op != OP_RS1);
    wr_flg = (op != OP_NOT) && (op != OP_RS0) && (op != OP_RS1);
    nxt_f.pf = st_pf;
    nxt_f.zf = st_zf;
    nxt_f.sf = st_sf;
    if (is_arith) begin
      nxt_f.cf = (op == OP_INC || op == OP_DEC) ? carry_i : as_cf;
      nxt_f.af = as_af;
      nxt_f.of = as_of;
    end else begin
      nxt_f.cf = lg_cf;
      nxt_f.af = 1'b0;
      nxt_f.of = lg_of;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (en_i) begin
      if (wr_res) result_q <= val;
      if (wr_flg) flags_q  <= nxt_f;
    end
  end

  assign result_o = result_q;
  assign cf_o = flags_q.cf;
  assign af_o = flags_q.af;
  assign pf_o = flags_q.pf;
  assign zf_o = flags_q.zf;
  assign sf_o = flags_q.sf;
  assign of_o = flags_q.of;
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic [3:0]  op_i,
  input logic        byte_i,
  input logic        carry_i,
  input logic [15:0] result_o,
  input logic        cf_o,
  input logic        af_o,
  input logic        pf_o,
  input logic        zf_o,
  input logic        sf_o,
  input logic        of_o
);
  logic [5:0] flg;
  logic       wr_both;
  assign flg     = {cf_o, af_o, pf_o, zf_o, sf_o, of_o};
  assign wr_both = (op_i <= 4'h6) || (op_i >= 4'h8 && op_i <= 4'hA) || op_i == 4'hC || op_i == 4'hD;

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (result_o == '0 && flg == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || op_i >= 4'hE) |=> ($stable(result_o) && $stable(flg))); // R12
  AST_CMP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 4'h7) |=> $stable(result_o)); // R8
  AST_NOT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 4'hB) |=> $stable(flg)); // R9
  AST_LOGIC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i >= 4'h8 && op_i <= 4'hA) |=> (!cf_o && !of_o && !af_o)); // R9
  AST_INCDEC_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (op_i == 4'h4 || op_i == 4'h5)) |=> (cf_o == $past(carry_i))); // R6
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_both) |=> (zf_o == (result_o == '0))); // R4
  AST_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_both) |=> (pf_o == ~^result_o[7:0])); // R4
  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && byte_i && wr_both) |=> (result_o[15:8] == '0 && sf_o == result_o[7])); // R11
endmodule

bind alu16 alu16_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i), .byte_i(byte_i),
  .carry_i(carry_i), .result_o(result_o), .cf_o(cf_o), .af_o(af_o), .pf_o(pf_o),
  .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
);

// File: tb/alu16_test.sv
module alu16_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] result_o;
  logic        cf_o, af_o, pf_o, zf_o, sf_o, of_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_res = '0;
  logic [5:0]  m_flg = '0;   // {cf,af,pf,zf,sf,of}

  always #4 clk_i = ~clk_i;

  alu16 uut (.*);

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  // Reference model written from the requirements with integer arithmetic.
  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic byt, input logic cin);
    int w, m, msk, ua, ub, sa, sb, t, st, res, c;
    logic cf, af, of, wr_r, wr_f, pf;
    w = byt ? 8 : 16; m = 1 << w; msk = m - 1;
    ua = int'(a) & msk; ub = int'(b) & msk;
    sa = (ua >= m/2) ? ua - m : ua;
    sb = (ub >= m/2) ? ub - m : ub;
    wr_r = 1'b1; wr_f = 1'b1; cf = 0; af = 0; of = 0; res = 0;
    if (op == 4'h4) begin ub = 1; sb = 1; end
    if (op == 4'h5) begin ub = 1; sb = 1; end
    if (op == 4'h6) begin ub = ua; sb = sa; ua = 0; sa = 0; end
    case (op)
      4'h0, 4'h1, 4'h4: begin
        c = (op == 4'h1) ? int'(cin) : 0;
        t = ua + ub + c; res = t & msk; cf = (t >= m);
        af = (((ua & 15) + (ub & 15) + c) > 15);
        st = sa + sb + c; of = (st >= m/2) || (st < -(m/2));
        if (op == 4'h4) cf = cin;
      end
      4'h2, 4'h3, 4'h5, 4'h6, 4'h7: begin
        c = (op == 4'h3) ? int'(cin) : 0;
        t = ua - ub - c; res = t & msk; cf = (t < 0);
        af = (((ua & 15) - (ub & 15) - c) < 0);
        st = sa - sb - c; of = (st >= m/2) || (st < -(m/2));
        if (op == 4'h5) cf = cin;
        if (op == 4'h7) wr_r = 1'b0;
      end
      4'h8: res = ua & ub;
      4'h9: res = ua | ub;
      4'hA: res = ua ^ ub;
      4'hB: begin res = (~ua) & msk; wr_f = 1'b0; end
      4'hC: begin res = (ua << 1) & msk; cf = (ua >> (w-1)) & 1; of = cf ^ ((res >> (w-1)) & 1); end
      4'hD: begin res = ua >> 1; cf = ua & 1; of = (ua >> (w-1)) & 1; end
      default: begin wr_r = 1'b0; wr_f = 1'b0; end
    endcase
    pf = 1'b1;
    for (int i = 0; i < 8; i++) if ((res >> i) & 1) pf = ~pf;
    if (wr_f) m_flg = {cf, af, pf, (res == 0), logic'((res >> (w-1)) & 1), of};
    if (wr_r) m_res = res[15:0];
  endtask

  task automatic compare(input string tag);
    checks++;
    if (result_o !== m_res || {cf_o, af_o, pf_o, zf_o, sf_o, of_o} !== m_flg) begin
      fails++;
      $display("FAIL %s: actual res=%h flags=%b expected res=%h flags=%b",
               tag, result_o, {cf_o, af_o, pf_o, zf_o, sf_o, of_o}, m_res, m_flg);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic [15:0] a,
                     input logic [15:0] b, input logic byt, input logic cin);
    @(negedge clk_i);
    en_i = 1'b1; op_i = op; a_i = a; b_i = b; byte_i = byt; carry_i = cin;
    model(op, a, b, byt, cin);
    @(negedge clk_i);
    en_i = 1'b0;
    compare(tag);
  endtask

  task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    #1 compare("R1 reset");
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_add();
    run("R2 add", 4'h0, 16'h1234, 16'h4321, 0, 0);
    check_val("R2 add value", result_o, 16'h5555);
    run("R2 add carry out", 4'h0, 16'hFFFF, 16'h0001, 0, 0);
    run("R2 adc", 4'h1, 16'h0010, 16'h0020, 0, 1);
    check_val("R2 adc value", result_o, 16'h0031);
    run("R3 nibble carry", 4'h0, 16'h000F, 16'h0001, 0, 0);
    run("R5 signed overflow add", 4'h0, 16'h7FFF, 16'h0001, 0, 0);
    run("R4 zero and parity", 4'h0, 16'h8000, 16'h8000, 0, 0);
  endtask

  task automatic t_sub();
    run("R2 sub borrow", 4'h2, 16'h0001, 16'h0002, 0, 0);
    run("R2 sbb", 4'h3, 16'h0100, 16'h0001, 0, 1);
    check_val("R2 sbb value", result_o, 16'h00FE);
    run("R5 signed overflow sub", 4'h2, 16'h8000, 16'h0001, 0, 0);
    run("R3 nibble borrow", 4'h2, 16'h0010, 16'h0001, 0, 0);
    run("R8 setup", 4'h0, 16'h1111, 16'h0000, 0, 0);
    run("R8 cmp equal", 4'h7, 16'h5A5A, 16'h5A5A, 0, 0);
    check_val("R8 cmp keeps result", result_o, 16'h1111);
    run("R8 cmp less", 4'h7, 16'h0003, 16'h0009, 0, 0);
  endtask

  task automatic t_incdec();
    run("R6 inc keeps carry 1", 4'h4, 16'hFFFF, 16'h0, 0, 1);
    run("R6 inc keeps carry 0", 4'h4, 16'h7FFF, 16'h0, 0, 0);
    run("R6 dec from zero", 4'h5, 16'h0000, 16'h0, 0, 0);
    run("R6 dec overflow", 4'h5, 16'h8000, 16'h0, 0, 1);
  endtask

  task automatic t_neg();
    run("R7 neg byte 35", 4'h6, 16'h0035, 16'h0, 1, 0);
    check_val("R7 neg value", result_o, 16'h00CB);
    run("R7 neg zero", 4'h6, 16'h0000, 16'h0, 0, 1);
    run("R7 neg min", 4'h6, 16'h8000, 16'h0, 0, 0);
  endtask

  task automatic t_logic();
    run("R9 prime flags", 4'h2, 16'h0000, 16'h0001, 0, 0);
    run("R9 and", 4'h8, 16'hF0F0, 16'hFF00, 0, 1);
    run("R9 or", 4'h9, 16'h0F00, 16'h00F0, 0, 0);
    run("R9 xor", 4'hA, 16'hAAAA, 16'hAAAA, 0, 0);
    run("R9 prime again", 4'h0, 16'hFFFF, 16'hFFFF, 0, 0);
    run("R9 not holds flags", 4'hB, 16'h00FF, 16'h0, 0, 0);
    check_val("R9 not value", result_o, 16'hFF00);
  endtask

  task automatic t_shift();
    run("R10 shl out", 4'hC, 16'h8001, 16'h0, 0, 0);
    run("R10 shl overflow", 4'hC, 16'h4000, 16'h0, 0, 0);
    run("R10 shr", 4'hD, 16'h8003, 16'h0, 0, 0);
    run("R10 shl byte", 4'hC, 16'h1281, 16'h0, 1, 0);
    run("R10 shr byte", 4'hD, 16'hFF80, 16'h0, 1, 0);
  endtask

  task automatic t_byte();
    run("R11 byte add carry", 4'h0, 16'h12FF, 16'h3401, 1, 0);
    check_val("R11 upper zero", result_o, 16'h0000);
    run("R11 byte overflow", 4'h0, 16'h007F, 16'h0001, 1, 0);
    run("R11 byte sub", 4'h2, 16'hAB00, 16'h0001, 1, 0);
    run("R4 parity word high bits ignored", 4'h9, 16'hFF03, 16'h0000, 0, 0);
  endtask

  task automatic t_idle();
    run("R12 setup", 4'h0, 16'h0F0F, 16'h0101, 0, 0);
    @(negedge clk_i);
    en_i = 1'b0; op_i = 4'h0; a_i = 16'hFFFF; b_i = 16'hFFFF; carry_i = 1'b1;
    @(negedge clk_i);
    compare("R12 disabled holds");
    run("R12 code E", 4'hE, 16'h1234, 16'h5678, 0, 1);
    run("R12 code F", 4'hF, 16'h0000, 16'h0000, 1, 0);
  endtask

  task automatic t_sweep();
    int unsigned s = 32'h1ACE_B00C;
    for (int k = 0; k < 400; k++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      run("R2 R12 sweep", s[3:0], s[31:16], {s[15:8], s[23:16]}, s[4], s[5]);
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_incdec();
    t_neg();
    t_logic();
    t_shift();
    t_byte();
    t_idle();
    t_sweep();
    summary();
  end
endmodule